// File: doc/BRIEF.md
# PC-Indexed Stride Prefetch Engine

This block sits beside a cache and watches the requests that missed in it. Each request brings a byte address, an instruction address with a flag saying whether that instruction address is valid, and a context tag. The engine keeps a small, fully associative table keyed by instruction address and context. Each entry remembers the last block address seen for that instruction, the last stride between block addresses, and a saturating confidence value.

When an instruction repeats the same non-zero stride, the engine emits a burst of predicted block addresses on a valid/ready output, one address per cycle. The burst ends early at a page boundary, and a counter records how many predicted addresses were dropped for that reason. While a burst is still draining, the request input is held off. When the table is full, a miss replaces the entry with the lowest confidence.

Top module: `pc_stride_prefetch`

## Requirements
- R1: A request accepted with `req_pc_valid` low has no effect. It does not look up the table, does not allocate an entry, emits no prefetch and leaves `span_drop_cnt` unchanged.
- R2: The block address is the request address with its low log2(BLK_BYTES) bits cleared. All stride arithmetic and every emitted address use block addresses.
- R3: With CTX_SPLIT=1, an entry matches only when both its instruction address and its context tag equal those of the request. A request from another context with the same instruction address misses.
- R4: On a hit, the new stride is the two's-complement difference of the current block address minus the stored last address. The stored last address is then replaced by the current block address on every hit.
- R5: On a hit, if the new stride equals the stored stride and is non-zero, confidence increments and saturates at CONF_MAX. Otherwise the stored stride becomes the new stride and confidence becomes 0. A newly allocated entry holds stride 0 and confidence 0.
- R6: A hit emits prefetches only if its updated confidence is non-zero. The addresses are block + d×stride for d = 1, 2, …, DEGREE, in that order. The first appears on `pf_addr` in the cycle after the request is accepted.
- R7: With PAGE_STOP=1, the burst ends just before the first candidate whose page (address bits from log2(PAGE_BYTES) upward) differs from the page of the triggering block. DEGREE − d + 1 is then added to `span_drop_cnt`, where d is that candidate's index.
- R8: Each cycle with `pf_valid` and `pf_ready` both high consumes one address. While `pf_ready` is low, `pf_valid` stays high and `pf_addr` is held.
- R9: `req_ready` is low while any address of a burst remains unconsumed, and high otherwise.
- R10: On a miss, the first invalid entry in index order is filled. If there is none, the entry with the lowest confidence is replaced, and a tie goes to the lowest index.
- R11: After reset the table is empty, `pf_valid` is 0, `req_ready` is 1 and `span_drop_cnt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Engine can take a request |
| req_addr | input | ADDR_W | Byte address of the miss |
| req_pc_valid | input | 1 | Instruction address field is meaningful |
| req_pc | input | PC_W | Instruction address of the miss |
| req_ctx | input | CTX_W | Context tag of the miss |
| pf_valid | output | 1 | Prefetch address present |
| pf_ready | input | 1 | Consumer takes the prefetch address |
| pf_addr | output | ADDR_W | Predicted block address |
| span_drop_cnt | output | SPAN_W | Running count of page-crossing prefetches dropped |

## Verification
The assertions assume that `pf_ready` may drop at any time but that a consumer never sees a burst change beneath it. They also assume that request fields are only meaningful in a cycle where `req_valid` and `req_ready` are both high. The stimulus drives requests only on the falling edge and keeps them steady until acceptance. It keeps addresses far from the top of the address space, so that stride arithmetic never wraps, and it uses strides that are whole blocks. Every scenario starts from a fresh reset, so each one's confidence history and span count are known exactly.

// File: rtl/pc_stride_prefetch.sv
module pc_stride_prefetch #(
  parameter int ENTRIES    = 16,
  parameter int ADDR_W     = 32,
  parameter int PC_W       = 32,
  parameter int CTX_W      = 2,
  parameter int BLK_BYTES  = 64,
  parameter int PAGE_BYTES = 4096,
  parameter int DEGREE     = 2,
  parameter int CONF_MAX   = 3,
  parameter bit CTX_SPLIT  = 1'b1,
  parameter bit PAGE_STOP  = 1'b1,
  parameter int SPAN_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_pc_valid,
  input  logic [PC_W-1:0]   req_pc,
  input  logic [CTX_W-1:0]  req_ctx,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_addr,
  output logic [SPAN_W-1:0] span_drop_cnt
);

  localparam int PG_LSB = $clog2(PAGE_BYTES);
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int CONF_W = (CONF_MAX > 1) ? $clog2(CONF_MAX + 1) : 1;
  localparam int DW     = $clog2(DEGREE + 1);
  localparam logic [ADDR_W-1:0] BLK_MASK = ~ADDR_W'(BLK_BYTES - 1);

  logic              v_q      [ENTRIES];
  logic [PC_W-1:0]   pc_q     [ENTRIES];
  logic [CTX_W-1:0]  ctx_q    [ENTRIES];
  logic [ADDR_W-1:0] last_q   [ENTRIES];
  logic [ADDR_W-1:0] stride_q [ENTRIES];
  logic [CONF_W-1:0] conf_q   [ENTRIES];

  logic [DW-1:0]     left_q;
  logic [ADDR_W-1:0] addr_q, bstride_q, trig_q;
  logic [SPAN_W-1:0] span_q;

  logic [CTX_W-1:0]  key_ctx;
  logic [ADDR_W-1:0] blk, new_stride;
  logic              fire, hit, vfree, match;
  logic [IDX_W-1:0]  hit_idx, vic;
  logic [CONF_W-1:0] vconf, conf_nxt;
  logic [DW-1:0]     cnt, drop;

  assign req_ready     = (left_q == '0);
  assign pf_valid      = (left_q != '0);
  assign pf_addr       = addr_q;
  assign span_drop_cnt = span_q;

  assign key_ctx = CTX_SPLIT ? req_ctx : '0;
  assign blk     = req_addr & BLK_MASK;
  assign fire    = req_valid && req_ready && req_pc_valid;

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!hit && v_q[i] && pc_q[i] == req_pc && ctx_q[i] == key_ctx) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    vic   = '0;
    vconf = conf_q[0];
    vfree = !v_q[0];
    for (int i = 1; i < ENTRIES; i++) begin
      if (!vfree) begin
        if (!v_q[i]) begin
          vfree = 1'b1;
          vic   = IDX_W'(i);
        end else if (conf_q[i] < vconf) begin
          vic   = IDX_W'(i);
          vconf = conf_q[i];
        end
      end
    end
  end

  assign new_stride = blk - last_q[hit_idx];
  assign match      = (new_stride == stride_q[hit_idx]) && (new_stride != '0);
  assign conf_nxt   = !match ? '0 :
                      (conf_q[hit_idx] == CONF_W'(CONF_MAX)) ? conf_q[hit_idx] :
                      conf_q[hit_idx] + 1'b1;

  always_comb begin
    logic [ADDR_W-1:0] cand;
    cnt  = DW'(DEGREE);
    drop = '0;
    for (int d = DEGREE; d >= 1; d--) begin
      cand = blk + ADDR_W'(d) * new_stride;
      if (PAGE_STOP && (((cand ^ blk) >> PG_LSB) != '0)) begin
        cnt  = DW'(d - 1);
        drop = DW'(DEGREE - d + 1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        v_q[i]      <= 1'b0;
        pc_q[i]     <= '0;
        ctx_q[i]    <= '0;
        last_q[i]   <= '0;
        stride_q[i] <= '0;
        conf_q[i]   <= '0;
      end
      left_q    <= '0;
      addr_q    <= '0;
      bstride_q <= '0;
      trig_q    <= '0;
      span_q    <= '0;
    end else begin
      if (pf_valid && pf_ready) begin
        left_q <= left_q - 1'b1;
        addr_q <= addr_q + bstride_q;
      end
      if (fire) begin
        if (hit) begin
          last_q[hit_idx]   <= blk;
          stride_q[hit_idx] <= new_stride;
          conf_q[hit_idx]   <= conf_nxt;
          if (conf_nxt != '0) begin
            span_q <= span_q + SPAN_W'(drop);
            if (cnt != '0) begin
              left_q    <= cnt;
              addr_q    <= blk + new_stride;
              bstride_q <= new_stride;
              trig_q    <= blk;
            end
          end
        end else begin
          v_q[vic]      <= 1'b1;
          pc_q[vic]     <= req_pc;
          ctx_q[vic]    <= key_ctx;
          last_q[vic]   <= blk;
          stride_q[vic] <= '0;
          conf_q[vic]   <= '0;
        end
      end
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_conf_chk
    a_r5_conf_cap: assert property (@(posedge clk) disable iff (!rst_n)
      conf_q[g] <= CONF_W'(CONF_MAX));
  end

  a_r1_no_pc_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_pc_valid) |=> (!pf_valid && $stable(span_q)));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_addr)));

  a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && pf_ready && left_q > DW'(1)) |=> (pf_addr == $past(pf_addr) + bstride_q));

  a_r7_same_page: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && PAGE_STOP) |-> (((pf_addr ^ trig_q) >> PG_LSB) == '0));

  a_r9_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready) |=> !req_ready);

endmodule

// File: tb/pc_stride_prefetch_tb_top.sv
module pc_stride_prefetch_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready, req_pc_valid = 1'b0;
  logic [31:0] req_addr = '0, req_pc = '0;
  logic [1:0]  req_ctx = '0;
  logic        pf_valid, pf_ready = 1'b1;
  logic [31:0] pf_addr;
  logic [15:0] span_drop_cnt;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  pc_stride_prefetch #(.ENTRIES(4), .DEGREE(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_pc_valid(req_pc_valid), .req_pc(req_pc),
    .req_ctx(req_ctx), .pf_valid(pf_valid), .pf_ready(pf_ready),
    .pf_addr(pf_addr), .span_drop_cnt(span_drop_cnt));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_valid = 1'b0; pf_ready = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send(input logic [31:0] pc, input logic [31:0] a,
                      input logic [1:0] ctx = 2'd0, input bit pcv = 1'b1);
    req_valid = 1'b1; req_pc = pc; req_addr = a; req_ctx = ctx; req_pc_valid = pcv;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_none(input string tag);
    chk(pf_valid == 1'b0, tag, 32'(pf_valid), 32'd0);
  endtask

  task automatic expect_burst(input logic [31:0] first, input logic [31:0] step,
                              input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      chk(pf_valid == 1'b1, tag, 32'(pf_valid), 32'd1);
      chk(pf_addr == first + 32'(k) * step, tag, pf_addr, first + 32'(k) * step);
      @(negedge clk);
    end
    chk(pf_valid == 1'b0, {tag, " end"}, 32'(pf_valid), 32'd0);
  endtask

  task automatic t_reset();
    do_reset();
    chk(pf_valid == 1'b0, "R11 pf_valid", 32'(pf_valid), 32'd0);
    chk(req_ready == 1'b1, "R11 req_ready", 32'(req_ready), 32'd1);
    chk(span_drop_cnt == 16'd0, "R11 span", 32'(span_drop_cnt), 32'd0);
  endtask

  task automatic t_basic();
    do_reset();
    send(32'hA, 32'h1000); expect_none("R10 alloc no pf");
    send(32'hA, 32'h1040); expect_none("R5 first stride conf0");
    send(32'hA, 32'h1080); expect_burst(32'h10C0, 32'h40, 3, "R6 burst");
    send(32'hA, 32'h9000, 2'd0, 1'b0); expect_none("R1 no pc");
    chk(span_drop_cnt == 16'd0, "R1 span", 32'(span_drop_cnt), 32'd0);
    send(32'hA, 32'h10C0); expect_burst(32'h1100, 32'h40, 3, "R1 R4 state kept");
    send(32'hA, 32'h10C0); expect_none("R5 zero stride resets");
    send(32'hA, 32'h1100); expect_none("R5 changed stride");
    send(32'hA, 32'h1140); expect_burst(32'h1180, 32'h40, 3, "R5 regain");
  endtask

  task automatic t_align();
    do_reset();
    send(32'hC, 32'h5013); send(32'hC, 32'h5055); expect_none("R2 conf0");
    send(32'hC, 32'h5099); expect_burst(32'h50C0, 32'h40, 3, "R2 aligned");
  endtask

  task automatic t_page();
    do_reset();
    send(32'hB, 32'h2F00); send(32'hB, 32'h2F40);
    send(32'hB, 32'h2F80); expect_burst(32'h2FC0, 32'h40, 1, "R7 cut");
    chk(span_drop_cnt == 16'd2, "R7 span", 32'(span_drop_cnt), 32'd2);
    do_reset();
    send(32'hD, 32'h8100); send(32'hD, 32'h80C0);
    send(32'hD, 32'h8080); expect_burst(32'h8040, 32'hFFFF_FFC0, 2, "R4 R7 negative");
    chk(span_drop_cnt == 16'd1, "R7 span neg", 32'(span_drop_cnt), 32'd1);
  endtask

  task automatic t_sat();
    do_reset();
    send(32'hF, 32'hC000); send(32'hF, 32'hC040);
    for (int k = 2; k < 7; k++) begin
      send(32'hF, 32'hC000 + 32'(k) * 32'h40);
      expect_burst(32'hC000 + 32'(k + 1) * 32'h40, 32'h40, 3, "R5 saturate");
    end
  endtask

  task automatic t_ctx();
    do_reset();
    send(32'hE, 32'hA000, 2'd0); send(32'hE, 32'hA040, 2'd0);
    send(32'hE, 32'hB000, 2'd1); expect_none("R3 other ctx miss");
    send(32'hE, 32'hA080, 2'd0); expect_burst(32'hA0C0, 32'h40, 3, "R3 own ctx");
  endtask

  task automatic t_backpressure();
    do_reset();
    send(32'h7, 32'hD000); send(32'h7, 32'hD040);
    pf_ready = 1'b0;
    send(32'h7, 32'hD080);
    for (int k = 0; k < 3; k++) begin
      chk(pf_valid == 1'b1, "R8 held valid", 32'(pf_valid), 32'd1);
      chk(pf_addr == 32'hD0C0, "R8 held addr", pf_addr, 32'hD0C0);
      chk(req_ready == 1'b0, "R9 ready low", 32'(req_ready), 32'd0);
      @(negedge clk);
    end
    pf_ready = 1'b1;
    expect_burst(32'hD0C0, 32'h40, 3, "R8 drain");
    chk(req_ready == 1'b1, "R9 ready back", 32'(req_ready), 32'd1);
  endtask

  task automatic t_evict();
    do_reset();
    send(32'h1, 32'h10000); send(32'h1, 32'h10040);
    send(32'h1, 32'h10080); expect_burst(32'h100C0, 32'h40, 3, "R10 p1");
    send(32'h2, 32'h20000); send(32'h2, 32'h20040);
    send(32'h2, 32'h20080); expect_burst(32'h200C0, 32'h40, 3, "R10 p2");
    send(32'h3, 32'h30000); send(32'h3, 32'h30040);
    send(32'h4, 32'h40000); send(32'h4, 32'h40040);
    send(32'h5, 32'h50000); expect_none("R10 p5 alloc");
    send(32'h3, 32'h30080); expect_none("R10 tie victim evicted");
    send(32'h4, 32'h40080); expect_burst(32'h400C0, 32'h40, 3, "R10 p4 kept");
    send(32'h1, 32'h100C0); expect_burst(32'h10100, 32'h40, 3, "R10 p1 kept");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_align();
    t_page();
    t_sat();
    t_ctx();
    t_backpressure();
    t_evict();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule